// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Trap and Interrupt Entry

This block is the main control state machine of a multicycle 32-bit load/store processor. Each instruction takes several clock cycles. The sequencer fetches the instruction, decodes its opcode and then walks the path for that instruction class through execute, memory access and register write-back. In every state it drives the select and enable lines of a datapath that lives outside this block: the ALU input muxes, the ALU operation class, the next-PC source, the memory and register-file strobes, and the exception registers.

Two more states handle exceptions. The trap state is entered on an undefined opcode or on an arithmetic overflow in an R-type execute. It drives the ALU so that the already-incremented PC is stepped back by four. The exception PC then captures the address of the faulting instruction, and the PC loads the handler vector. The interrupt state is entered at the end of any instruction while an interrupt is pending. It captures the address of the next instruction instead. A small exception code goes out alongside these states to be written into the cause register.

All control outputs are registered. The state and the control word it implies are loaded on the same edge, so in any cycle the outputs are exactly the controls of the current state. The only combinational output is the merged PC load enable, which folds in the ALU zero flag for branches.

Top module: `mcc_ctrl`

## Requirements
- R1: After a synchronous reset the sequencer is in state 0 (fetch), with the fetch controls on the outputs and an exception code of 0.
- R2: State 0 asserts pc_wr, mem_rd and ir_wr, with addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00 and pc_src=00, and always moves to state 1. State 1 drives alu_a_sel=0, alu_b_sel=11 and alu_op=00, with no strobes.
- R3: From state 1 the next state depends on the opcode. Opcode 0x00 (R-type) goes to 6, 0x23 (load) and 0x2B (store) go to 2, 0x04 (branch-if-equal) goes to 8, and 0x02 (jump) goes to 9.
- R4: State 2 drives alu_a_sel=1, alu_b_sel=10 and alu_op=00, then goes to 3 for a load or 5 for a store. State 3 asserts mem_rd with addr_sel=1 and goes to 4. State 4 asserts rf_wr with wb_sel=1 and rf_dst=0. State 5 asserts mem_wr with addr_sel=1. mem_rd and mem_wr are never asserted together.
- R5: State 6 drives alu_a_sel=1, alu_b_sel=00 and alu_op=10. Without overflow it goes to 7, which asserts rf_wr with rf_dst=1 and wb_sel=0.
- R6: An overflow flag seen in state 6 sends the sequencer to state 10 instead of 7, so no register write takes place, and the exception code becomes 12. The overflow flag has no effect in any other state.
- R7: Any opcode other than the five in R3 sends state 1 to state 10, with exception code 10.
- R8: State 10 asserts epc_wr, cause_wr and pc_wr, with exc_kind=1, pc_src=11, alu_a_sel=0, alu_b_sel=01 and alu_op=01.
- R9: States 4, 5, 7, 8 and 9 go to state 11 when irq_pending is high and to state 0 otherwise. State 11 asserts epc_wr, cause_wr and pc_wr, with exc_kind=0, pc_src=11 and exception code 0.
- R10: States 10 and 11 always go to state 0, whatever irq_pending is.
- R11: State 8 asserts pc_wr_cond with alu_a_sel=1, alu_b_sel=00, alu_op=01 and pc_src=01. pc_load equals pc_wr OR (pc_wr_cond AND alu_zero).
- R12: State 9 asserts pc_wr with pc_src=10, and nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W (6) | Opcode field of the instruction register |
| alu_ovf | input | 1 | ALU signed overflow flag |
| alu_zero | input | 1 | ALU zero flag |
| irq_pending | input | 1 | An enabled interrupt is pending |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if the ALU result is zero |
| pc_load | output | 1 | Merged PC load enable |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 = ALU result, 1 = memory data |
| pc_src | output | 2 | Next PC: 00 ALU, 01 ALU result reg, 10 jump target, 11 handler vector |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A input: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B input: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write |
| rf_dst | output | 1 | Destination field: 0 = rt, 1 = rd |
| epc_wr | output | 1 | Exception PC write |
| cause_wr | output | 1 | Cause and status register write |
| exc_kind | output | 1 | EPC source: 1 = ALU (PC-4), 0 = current PC |
| exc_code | output | CODE_W (5) | Exception code for the cause register |
| fsm_state | output | 4 | Current state number |

## Verification
The embedded properties check, on every cycle, the transitions that do not depend on the instruction mix. Fetch always leads to decode, both exception states always return to fetch, and a pending interrupt at any last state leads to the interrupt state. They also check that overflow in R-type execute enters the trap state with code 12 and no register write, and that memory read and write never coincide. The bench's scenarios are needed for the rest. Only they show the full control vector in each state of each instruction path, the decode dispatch per opcode, the reserved-instruction trap code, the branch PC enable as a function of the zero flag, and that overflow and interrupt inputs have no effect outside the states that sample them.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int STW = 4;

  typedef enum logic [STW-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MADDR  = 4'd2,
    S_LDRD   = 4'd3,
    S_LDWB   = 4'd4,
    S_STWR   = 4'd5,
    S_REXE   = 4'd6,
    S_RWB    = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9,
    S_TRAP   = 4'd10,
    S_INTR   = 4'd11
  } state_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam int CODE_RSVD = 10;
  localparam int CODE_OVF  = 12;
  localparam int CODE_INT  = 0;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_sel;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst;
    logic       epc_wr;
    logic       cause_wr;
    logic       exc_kind;
  } ctrl_t;
endpackage

// File: rtl/mcc_next.sv
module mcc_next
  import mcc_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  state_t          cur,
  input  logic [OP_W-1:0] opcode,
  input  logic            alu_ovf,
  input  logic            irq_pending,
  output state_t          nxt
);
  localparam state_t END_TARGET_IRQ = S_INTR;

  logic [5:0] op6;
  assign op6 = 6'(opcode);

  state_t end_target;
  assign end_target = irq_pending ? END_TARGET_IRQ : S_FETCH;

  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (op6)
          OP_RTYPE:         nxt = S_REXE;
          OP_LOAD,OP_STORE: nxt = S_MADDR;
          OP_BEQ:           nxt = S_BRANCH;
          OP_JUMP:          nxt = S_JUMP;
          default:          nxt = S_TRAP;
        endcase
      end
      S_MADDR:  nxt = (op6 == OP_LOAD) ? S_LDRD : S_STWR;
      S_LDRD:   nxt = S_LDWB;
      S_REXE:   nxt = alu_ovf ? S_TRAP : S_RWB;
      S_LDWB, S_STWR, S_RWB, S_BRANCH, S_JUMP: nxt = end_target;
      S_TRAP, S_INTR: nxt = S_FETCH;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
  import mcc_pkg::*;
(
  input  state_t st,
  output ctrl_t  ctl
);
  always_comb begin
    ctl = '0;
    unique case (st)
      S_FETCH: begin
        ctl.pc_wr = 1'b1; ctl.mem_rd = 1'b1; ctl.ir_wr = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      S_DECODE: ctl.alu_b_sel = 2'b11;
      S_MADDR: begin
        ctl.alu_a_sel = 1'b1; ctl.alu_b_sel = 2'b10;
      end
      S_LDRD: begin
        ctl.mem_rd = 1'b1; ctl.addr_sel = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_wr = 1'b1; ctl.wb_sel = 1'b1;
      end
      S_STWR: begin
        ctl.mem_wr = 1'b1; ctl.addr_sel = 1'b1;
      end
      S_REXE: begin
        ctl.alu_a_sel = 1'b1; ctl.alu_op = 2'b10;
      end
      S_RWB: begin
        ctl.rf_wr = 1'b1; ctl.rf_dst = 1'b1;
      end
      S_BRANCH: begin
        ctl.alu_a_sel = 1'b1; ctl.alu_op = 2'b01;
        ctl.pc_src = 2'b01; ctl.pc_wr_cond = 1'b1;
      end
      S_JUMP: begin
        ctl.pc_src = 2'b10; ctl.pc_wr = 1'b1;
      end
      S_TRAP: begin
        ctl.cause_wr = 1'b1; ctl.epc_wr = 1'b1; ctl.pc_wr = 1'b1;
        ctl.exc_kind = 1'b1; ctl.pc_src = 2'b11;
        ctl.alu_b_sel = 2'b01; ctl.alu_op = 2'b01;
      end
      S_INTR: begin
        ctl.cause_wr = 1'b1; ctl.epc_wr = 1'b1; ctl.pc_wr = 1'b1;
        ctl.pc_src = 2'b11;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
#(
  parameter int OP_W   = 6,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              alu_ovf,
  input  logic              alu_zero,
  input  logic              irq_pending,
  output logic              pc_wr,
  output logic              pc_wr_cond,
  output logic              pc_load,
  output logic              addr_sel,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              ir_wr,
  output logic              wb_sel,
  output logic [1:0]        pc_src,
  output logic [1:0]        alu_op,
  output logic              alu_a_sel,
  output logic [1:0]        alu_b_sel,
  output logic              rf_wr,
  output logic              rf_dst,
  output logic              epc_wr,
  output logic              cause_wr,
  output logic              exc_kind,
  output logic [CODE_W-1:0] exc_code,
  output logic [3:0]        fsm_state
);
  state_t state_q, state_nx, state_in;
  ctrl_t  ctl_d, ctl_q;
  logic [CODE_W-1:0] code_d, code_q;

  mcc_next #(.OP_W(OP_W)) u_next (
    .cur(state_q), .opcode(opcode), .alu_ovf(alu_ovf),
    .irq_pending(irq_pending), .nxt(state_nx)
  );

  assign state_in = rst ? S_FETCH : state_nx;

  mcc_decode u_dec (.st(state_in), .ctl(ctl_d));

  always_comb begin
    code_d = CODE_W'(CODE_INT);
    if (state_in == S_TRAP)
      code_d = (state_q == S_REXE) ? CODE_W'(CODE_OVF) : CODE_W'(CODE_RSVD);
  end

  always_ff @(posedge clk) begin
    state_q <= state_in;
    ctl_q   <= ctl_d;
    code_q  <= rst ? '0 : code_d;
  end

  assign pc_wr      = ctl_q.pc_wr;
  assign pc_wr_cond = ctl_q.pc_wr_cond;
  assign pc_load    = ctl_q.pc_wr | (ctl_q.pc_wr_cond & alu_zero);
  assign addr_sel   = ctl_q.addr_sel;
  assign mem_rd     = ctl_q.mem_rd;
  assign mem_wr     = ctl_q.mem_wr;
  assign ir_wr      = ctl_q.ir_wr;
  assign wb_sel     = ctl_q.wb_sel;
  assign pc_src     = ctl_q.pc_src;
  assign alu_op     = ctl_q.alu_op;
  assign alu_a_sel  = ctl_q.alu_a_sel;
  assign alu_b_sel  = ctl_q.alu_b_sel;
  assign rf_wr      = ctl_q.rf_wr;
  assign rf_dst     = ctl_q.rf_dst;
  assign epc_wr     = ctl_q.epc_wr;
  assign cause_wr   = ctl_q.cause_wr;
  assign exc_kind   = ctl_q.exc_kind;
  assign exc_code   = code_q;
  assign fsm_state  = state_q;

  logic at_end;
  assign at_end = (state_q == S_LDWB) || (state_q == S_STWR) || (state_q == S_RWB) ||
                  (state_q == S_BRANCH) || (state_q == S_JUMP);

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_FETCH) |=> (fsm_state == 4'd1));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_REXE && alu_ovf) |=>
      (fsm_state == 4'd10 && exc_code == CODE_W'(CODE_OVF) && !rf_wr));

  p_irq_entry_r9: assert property (@(posedge clk) disable iff (rst)
    (at_end && irq_pending) |=> (fsm_state == 4'd11 && exc_code == '0 && !exc_kind));

  p_exc_return_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_TRAP || state_q == S_INTR) |=> (fsm_state == 4'd0));

  p_mem_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_trap_vector_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(exc_kind) |-> (epc_wr && cause_wr && pc_src == 2'b11));
endmodule

// File: tb/mcc_ctrl_test.sv
module mcc_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic alu_ovf = 1'b0, alu_zero = 1'b0, irq_pending = 1'b0;
  logic pc_wr, pc_wr_cond, pc_load, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic alu_a_sel, rf_wr, rf_dst, epc_wr, cause_wr, exc_kind;
  logic [4:0] exc_code;
  logic [3:0] fsm_state;
  int n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;

  mcc_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf), .alu_zero(alu_zero),
    .irq_pending(irq_pending), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_load(pc_load),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel(wb_sel),
    .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .rf_wr(rf_wr), .rf_dst(rf_dst), .epc_wr(epc_wr), .cause_wr(cause_wr),
    .exc_kind(exc_kind), .exc_code(exc_code), .fsm_state(fsm_state)
  );

  // Bit order: pc_wr pc_wr_cond addr_sel mem_rd mem_wr ir_wr wb_sel pc_src alu_op
  //            alu_a_sel alu_b_sel rf_wr rf_dst epc_wr cause_wr exc_kind
  function automatic logic [18:0] exp_word(input int s);
    logic pw = 0, pwc = 0, as = 0, mr = 0, mw = 0, iw = 0, wbs = 0, aa = 0;
    logic rw = 0, rd = 0, ew = 0, cw = 0, ek = 0;
    logic [1:0] ps = 0, ao = 0, ab = 0;
    case (s)
      0:  begin pw = 1; mr = 1; iw = 1; ab = 2'b01; end
      1:  ab = 2'b11;
      2:  begin aa = 1; ab = 2'b10; end
      3:  begin mr = 1; as = 1; end
      4:  begin rw = 1; wbs = 1; end
      5:  begin mw = 1; as = 1; end
      6:  begin aa = 1; ao = 2'b10; end
      7:  begin rw = 1; rd = 1; end
      8:  begin aa = 1; ao = 2'b01; ps = 2'b01; pwc = 1; end
      9:  begin ps = 2'b10; pw = 1; end
      10: begin cw = 1; ew = 1; pw = 1; ek = 1; ps = 2'b11; ab = 2'b01; ao = 2'b01; end
      11: begin cw = 1; ew = 1; pw = 1; ps = 2'b11; end
      default: ;
    endcase
    return {pw, pwc, as, mr, mw, iw, wbs, ps, ao, aa, ab, rw, rd, ew, cw, ek};
  endfunction

  function automatic logic [18:0] act_word();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel, pc_src, alu_op,
            alu_a_sel, alu_b_sel, rf_wr, rf_dst, epc_wr, cause_wr, exc_kind};
  endfunction

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(input int st, input int code, input string req);
    n_checks++;
    if (fsm_state !== 4'(st) || act_word() !== exp_word(st) || exc_code !== 5'(code)) begin
      n_fail++;
      $display("FAIL %s: state=%0d ctl=%b code=%0d expected state=%0d ctl=%b code=%0d",
               req, fsm_state, act_word(), exc_code, st, exp_word(st), code);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    check(0, 0, "R1 reset to fetch");
  endtask

  task automatic t_load();   // R2 R3 R4, overflow ignored outside execute (R6)
    opcode = 6'h23; alu_ovf = 1'b1;
    tick(); check(1, 0, "R2 fetch to decode");
    tick(); check(2, 0, "R3 load dispatch");
    tick(); check(3, 0, "R4 load read");
    tick(); check(4, 0, "R4 load writeback, R6 ovf ignored");
    alu_ovf = 1'b0;
    tick(); check(0, 0, "R9 end to fetch");
  endtask

  task automatic t_store_irq();
    opcode = 6'h2B;
    tick(); check(1, 0, "R2 decode");
    tick(); check(2, 0, "R3 store dispatch");
    irq_pending = 1'b1;
    tick(); check(5, 0, "R4 store write, irq ignored mid-instr");
    tick(); check(11, 0, "R9 store end to interrupt");
    irq_pending = 1'b0;
    tick(); check(0, 0, "R10 interrupt return");
  endtask

  task automatic t_rtype();
    opcode = 6'h00;
    tick(); tick(); check(6, 0, "R3 rtype dispatch");
    tick(); check(7, 0, "R5 rtype writeback");
    tick(); check(0, 0, "R5 back to fetch");
  endtask

  task automatic t_overflow();
    opcode = 6'h00;
    tick(); tick(); check(6, 0, "R5 rtype execute");
    alu_ovf = 1'b1; irq_pending = 1'b1;
    tick(); check(10, 12, "R6 overflow trap code 12, R8 trap controls");
    check_bit(rf_wr, 1'b0, "R6 no register write");
    alu_ovf = 1'b0;
    tick(); check(0, 0, "R10 trap return despite irq");
    irq_pending = 1'b0;
  endtask

  task automatic t_branch();
    opcode = 6'h04;
    tick(); tick(); check(8, 0, "R11 branch controls");
    alu_zero = 1'b1; #1 check_bit(pc_load, 1'b1, "R11 pc_load with zero");
    alu_zero = 1'b0; #1 check_bit(pc_load, 1'b0, "R11 pc_load without zero");
    tick(); check(0, 0, "R9 branch end to fetch");
    check_bit(pc_load, 1'b1, "R11 pc_load in fetch");
  endtask

  task automatic t_jump_irq();
    opcode = 6'h02;
    tick(); tick(); check(9, 0, "R12 jump controls");
    irq_pending = 1'b1;
    tick(); check(11, 0, "R9 jump end to interrupt");
    tick(); check(0, 0, "R10 interrupt return despite irq");
    irq_pending = 1'b0;
  endtask

  task automatic t_reserved();
    opcode = 6'h3F;
    tick(); check(1, 0, "R7 decode");
    tick(); check(10, 10, "R7 reserved trap code 10");
    tick(); check(0, 0, "R10 trap return");
    opcode = 6'h05;
    tick(); tick(); check(10, 10, "R7 near-branch opcode traps");
    tick(); check(0, 0, "R10 trap return");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load();
        t_store_irq();
        t_rtype();
        t_overflow();
        t_branch();
        t_jump_irq();
        t_reserved();
        t_reset();
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule